// File: doc/BRIEF.md
# Hardware Real-Time Thread Scheduler

This block chooses, on every clock cycle, which of four hardware threads in an interleaved pipeline issues next. The grant depends only on the current inputs and on a small amount of internal state. Switching from one thread to another therefore costs no extra cycles: the grant in a cycle reflects the readiness and parameters present in that same cycle.

Software sets one of four policies through a two-bit selector:

- Fixed priority preemptive: the highest static priority wins.
- Earliest deadline: the smallest deadline wins.
- Least laxity: the smallest value of deadline minus current time minus remaining execution wins.
- Reserved share: each thread is guaranteed a percentage of the cycles in a repeating interval.

The block keeps the following state:

- A free-running time counter.
- A remaining-execution counter for each thread. Each one is loaded by a strobe and counts down once for every cycle its thread is granted.
- An interval counter.
- A usage counter for each thread, used by the reserved-share policy.

Top module: `rt_thread_sched`

## Requirements
- R1: The grant outputs are combinational in the current inputs and state, so a change of readiness or policy is reflected in the same cycle with no switch penalty.
- R2: With policySel = 0 (fixed priority), the ready thread with the numerically largest priority field is granted.
- R3: With policySel = 1 (earliest deadline), the ready thread with the numerically smallest deadline field is granted.
- R4: With policySel = 2 (least laxity), the granted thread is the ready one with the smallest signed value of deadline - time - remaining. Each remaining counter behaves as follows:
  - A set bit in execLoad loads it from execFlat at the clock edge, and the load wins over a decrement.
  - Otherwise it drops by one at each edge where its thread is granted, and it saturates at zero.
- R5: In every policy, a tie in the compared key is resolved toward the lowest thread index.
- R6: A thread whose readyMask bit is clear is never granted. When no thread is ready, grantValid is 0 and grantOneHot is all zeros.
- R7: grantOneHot has exactly bit grantIdx set when grantValid is 1. Thread i occupies bits [i*W +: W] of every flat input.
- R8: With policySel = 3 (reserved share), thread i is entitled to floor(intervalLen * share_i / 100) cycles in each interval. Ready threads that are still below their entitlement are served first, lowest index first. Any remaining cycle goes to the lowest-index ready thread.
- R9: The interval counter starts at 0 after reset and wraps after intervalLen cycles. At each wrap, all usage counters are cleared, so the entitlements repeat each interval.
- R10: If the share fields sum to more than 100, quotaErr is 1. The shares are then granted in index order from a budget of 100, each thread receiving the lesser of its request and what remains.
- R11: Reset clears the time, interval, usage and remaining counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| policySel | input | 2 | Policy: 0 fixed priority, 1 earliest deadline, 2 least laxity, 3 reserved share |
| readyMask | input | 4 | One ready bit per thread |
| prioFlat | input | 4*PRIO_W | Static priority per thread |
| deadlineFlat | input | 4*TIME_W | Absolute deadline per thread |
| execLoad | input | 4 | Load strobe for each remaining-execution counter |
| execFlat | input | 4*TIME_W | Remaining-execution load values |
| pctFlat | input | 4*PCT_W | Reserved share per thread, in percent |
| intervalLen | input | INTV_W | Interval length in cycles |
| grantOneHot | output | 4 | One-hot grant |
| grantIdx | output | 2 | Encoded grant |
| grantValid | output | 1 | A thread is granted |
| quotaErr | output | 1 | Share sum exceeds 100 |

## Verification
A vector table first exercises the priority and deadline policies:

- Distinct keys show that the correct ordering direction is used.
- Equal keys expose the tie rule.
- Masked-out winners show that readiness filters the choice.
- An empty mask checks the idle output.

A reserved-share run with shares of 20, 40, 30 and 0 over a ten-cycle interval is followed cycle by cycle across two intervals. It separates quota service from surplus service and confirms the wrap. A run with oversubscribed shares and a sparse ready mask separates in-order clamping from unclamped shares. A least-laxity run with a loaded remaining count shows the countdown changing the winner by way of a tie.

// File: rtl/rts_pkg.sv
package rts_pkg;
  localparam int NUM_THR = 4;
  localparam int IDX_W   = $clog2(NUM_THR);

  typedef enum logic [1:0] {
    POL_FPP = 2'd0,
    POL_EDF = 2'd1,
    POL_LLF = 2'd2,
    POL_GP  = 2'd3
  } policy_e;

  // Strobes from the selector to the counters
  typedef struct packed {
    logic             issue;
    logic [IDX_W-1:0] idx;
    logic             countUse;
  } sched_strobe_t;
endpackage

// File: rtl/rts_datapath.sv
module rts_datapath
  import rts_pkg::*;
#(
  parameter int TIME_W = 16,
  parameter int PCT_W  = 7,
  parameter int INTV_W = 12,
  localparam int LAX_W  = TIME_W + 2,
  localparam int SUM_W  = PCT_W + IDX_W,
  localparam int PROD_W = INTV_W + PCT_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  sched_strobe_t               strobe,
  input  logic [NUM_THR-1:0]          execLoad,
  input  logic [NUM_THR*TIME_W-1:0]   execFlat,
  input  logic [NUM_THR*TIME_W-1:0]   deadlineFlat,
  input  logic [NUM_THR*PCT_W-1:0]    pctFlat,
  input  logic [INTV_W-1:0]           intervalLen,
  output logic [NUM_THR*LAX_W-1:0]    laxFlat,
  output logic [NUM_THR-1:0]          underQuota,
  output logic                        quotaErr
);

  logic [TIME_W-1:0] timeNow;
  logic [INTV_W-1:0] intvCnt;
  logic              intvWrap;
  logic [PCT_W-1:0]  effPct [NUM_THR];
  logic [INTV_W-1:0] quotaCyc [NUM_THR];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timeNow <= '0;
    else       timeNow <= timeNow + 1'b1;
  end

  assign intvWrap = (intervalLen <= INTV_W'(1)) || (intvCnt >= intervalLen - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         intvCnt <= '0;
    else if (intvWrap) intvCnt <= '0;
    else               intvCnt <= intvCnt + 1'b1;
  end

  // Shares granted in index order out of a budget of 100
  always_comb begin
    logic [SUM_W-1:0] budget;
    logic [SUM_W-1:0] pctSum;
    budget = SUM_W'(100);
    pctSum = '0;
    for (int i = 0; i < NUM_THR; i++) begin
      logic [PCT_W-1:0] req;
      req    = pctFlat[i*PCT_W +: PCT_W];
      pctSum = pctSum + SUM_W'(req);
      if (SUM_W'(req) > budget) effPct[i] = budget[PCT_W-1:0];
      else                      effPct[i] = req;
      budget = budget - SUM_W'(effPct[i]);
      quotaCyc[i] = INTV_W'((PROD_W'(intervalLen) * PROD_W'(effPct[i])) / PROD_W'(100));
    end
    quotaErr = pctSum > SUM_W'(100);
  end

  for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
    logic [TIME_W-1:0] remCnt;
    logic [INTV_W-1:0] usedCnt;
    logic              hit;

    assign hit = strobe.issue && (strobe.idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                    remCnt <= '0;
      else if (execLoad[g])         remCnt <= execFlat[g*TIME_W +: TIME_W];
      else if (hit && remCnt != '0) remCnt <= remCnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                         usedCnt <= '0;
      else if (intvWrap)                 usedCnt <= '0;
      else if (hit && strobe.countUse)   usedCnt <= usedCnt + 1'b1;
    end

    assign underQuota[g] = usedCnt < quotaCyc[g];
    assign laxFlat[g*LAX_W +: LAX_W] = LAX_W'(deadlineFlat[g*TIME_W +: TIME_W])
                                     - LAX_W'(timeNow) - LAX_W'(remCnt);

    // R4
    rem_nogrow_chk: assert property (@(posedge clk) disable iff (!rstN)
      !$past(execLoad[g]) |-> remCnt <= $past(remCnt));
    // R8
    used_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
      usedCnt <= intvCnt);
    // R9
    used_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      $past(intvWrap) |-> usedCnt == '0);
  end

endmodule

// File: rtl/rts_control.sv
module rts_control
  import rts_pkg::*;
#(
  parameter int PRIO_W = 4,
  parameter int TIME_W = 16,
  localparam int LAX_W = TIME_W + 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  policy_e                    policy,
  input  logic [NUM_THR-1:0]         readyMask,
  input  logic [NUM_THR*PRIO_W-1:0]  prioFlat,
  input  logic [NUM_THR*TIME_W-1:0]  deadlineFlat,
  input  logic [NUM_THR*LAX_W-1:0]   laxFlat,
  input  logic [NUM_THR-1:0]         underQuota,
  output sched_strobe_t              strobe,
  output logic [NUM_THR-1:0]         grantOneHot
);

  logic [PRIO_W-1:0] prio [NUM_THR];
  logic [TIME_W-1:0] dl   [NUM_THR];
  logic [LAX_W-1:0]  lax  [NUM_THR];
  logic [NUM_THR-1:0] candMask;
  logic               found;
  logic [IDX_W-1:0]   best;

  for (genvar g = 0; g < NUM_THR; g++) begin : g_unpack
    assign prio[g] = prioFlat[g*PRIO_W +: PRIO_W];
    assign dl[g]   = deadlineFlat[g*TIME_W +: TIME_W];
    assign lax[g]  = laxFlat[g*LAX_W +: LAX_W];
  end

  always_comb begin
    candMask = readyMask;
    if (policy == POL_GP && |(readyMask & underQuota))
      candMask = readyMask & underQuota;
    found = 1'b0;
    best  = '0;
    for (int i = 0; i < NUM_THR; i++) begin
      if (candMask[i]) begin
        if (!found) begin
          found = 1'b1;
          best  = IDX_W'(i);
        end else begin
          unique case (policy)
            POL_FPP: if (prio[i] > prio[best]) best = IDX_W'(i);
            POL_EDF: if (dl[i] < dl[best]) best = IDX_W'(i);
            POL_LLF: if ($signed(lax[i]) < $signed(lax[best])) best = IDX_W'(i);
            default: ;
          endcase
        end
      end
    end
  end

  assign strobe.issue    = found;
  assign strobe.idx      = best;
  assign strobe.countUse = found && (policy == POL_GP);
  assign grantOneHot     = found ? (NUM_THR'(1) << best) : '0;

  // R6
  grant_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grantOneHot & ~readyMask) == '0);
  // R6
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issue == (|readyMask));
  // R7
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantOneHot) && (strobe.issue == (|grantOneHot)));

endmodule

// File: rtl/rt_thread_sched.sv
module rt_thread_sched
  import rts_pkg::*;
#(
  parameter int PRIO_W = 4,
  parameter int TIME_W = 16,
  parameter int PCT_W  = 7,
  parameter int INTV_W = 12,
  localparam int LAX_W = TIME_W + 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [1:0]                 policySel,
  input  logic [NUM_THR-1:0]         readyMask,
  input  logic [NUM_THR*PRIO_W-1:0]  prioFlat,
  input  logic [NUM_THR*TIME_W-1:0]  deadlineFlat,
  input  logic [NUM_THR-1:0]         execLoad,
  input  logic [NUM_THR*TIME_W-1:0]  execFlat,
  input  logic [NUM_THR*PCT_W-1:0]   pctFlat,
  input  logic [INTV_W-1:0]          intervalLen,
  output logic [NUM_THR-1:0]         grantOneHot,
  output logic [IDX_W-1:0]           grantIdx,
  output logic                       grantValid,
  output logic                       quotaErr
);

  sched_strobe_t              strobe;
  logic [NUM_THR*LAX_W-1:0]   laxFlat;
  logic [NUM_THR-1:0]         underQuota;

  rts_control #(.PRIO_W(PRIO_W), .TIME_W(TIME_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .policy       (policy_e'(policySel)),
    .readyMask    (readyMask),
    .prioFlat     (prioFlat),
    .deadlineFlat (deadlineFlat),
    .laxFlat      (laxFlat),
    .underQuota   (underQuota),
    .strobe       (strobe),
    .grantOneHot  (grantOneHot)
  );

  rts_datapath #(.TIME_W(TIME_W), .PCT_W(PCT_W), .INTV_W(INTV_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .execLoad     (execLoad),
    .execFlat     (execFlat),
    .deadlineFlat (deadlineFlat),
    .pctFlat      (pctFlat),
    .intervalLen  (intervalLen),
    .laxFlat      (laxFlat),
    .underQuota   (underQuota),
    .quotaErr     (quotaErr)
  );

  assign grantIdx   = strobe.idx;
  assign grantValid = strobe.issue;

endmodule

// File: tb/rt_thread_sched_tb.sv
module rt_thread_sched_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  policySel = '0;
  logic [3:0]  readyMask = '0;
  logic [15:0] prioFlat = '0;
  logic [63:0] deadlineFlat = '0;
  logic [3:0]  execLoad = '0;
  logic [63:0] execFlat = '0;
  logic [27:0] pctFlat = '0;
  logic [11:0] intervalLen = 12'd10;
  logic [3:0]  grantOneHot;
  logic [1:0]  grantIdx;
  logic        grantValid;
  logic        quotaErr;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  rt_thread_sched u_dut (
    .clk(clk), .rstN(rstN), .policySel(policySel), .readyMask(readyMask),
    .prioFlat(prioFlat), .deadlineFlat(deadlineFlat), .execLoad(execLoad),
    .execFlat(execFlat), .pctFlat(pctFlat), .intervalLen(intervalLen),
    .grantOneHot(grantOneHot), .grantIdx(grantIdx), .grantValid(grantValid),
    .quotaErr(quotaErr)
  );

  // {mode, ready, prio(T3..T0), 8-bit deadlines(T3..T0), expValid, expIdx}
  localparam logic [56:0] VEC [0:9] = '{
    {2'd0, 4'b1111, 16'h1234, 32'h00000000, 1'b1, 2'd0}, // R2
    {2'd0, 4'b1110, 16'h1234, 32'h00000000, 1'b1, 2'd1}, // R2 R6
    {2'd0, 4'b1111, 16'h7117, 32'h00000000, 1'b1, 2'd0}, // R5
    {2'd0, 4'b1000, 16'h1234, 32'h00000000, 1'b1, 2'd3}, // R6
    {2'd0, 4'b0000, 16'h1234, 32'h00000000, 1'b0, 2'd0}, // R6 idle
    {2'd1, 4'b1111, 16'h0000, 32'h10203040, 1'b1, 2'd3}, // R3
    {2'd1, 4'b0111, 16'h0000, 32'h10203040, 1'b1, 2'd2}, // R3 R6
    {2'd1, 4'b1111, 16'h0000, 32'h50505050, 1'b1, 2'd0}, // R5
    {2'd1, 4'b0110, 16'h0000, 32'h05FF01FF, 1'b1, 2'd1}, // R3
    {2'd2, 4'b1111, 16'h0000, 32'h30302010, 1'b1, 2'd0}  // R4 zero remaining
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    execLoad = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  function automatic int oh(input logic v, input int idx);
    return v ? (1 << idx) : 0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R11 reset state
    doReset();
    #1;
    chk("R11 valid", int'(grantValid), 0);
    chk("R11 onehot", int'(grantOneHot), 0);
    chk("R11 quotaErr", int'(quotaErr), 0);

    // vector table: R1 same-cycle response
    for (int v = 0; v < 10; v++) begin
      logic [56:0] e;
      e = VEC[v];
      @(negedge clk);
      policySel = e[56:55];
      readyMask = e[54:51];
      prioFlat  = e[50:35];
      for (int t = 0; t < 4; t++) deadlineFlat[t*16 +: 16] = {8'h00, e[3+t*8 +: 8]};
      #1;
      chk("R1 R2 R3 valid", int'(grantValid), int'(e[2]));
      chk("R7 onehot", int'(grantOneHot), oh(e[2], int'(e[1:0])));
      if (e[2]) chk("R7 idx", int'(grantIdx), int'(e[1:0]));
    end

    // R8 R9 reserved share: 20/40/30/0 over 10 cycles
    @(negedge clk);
    policySel = 2'd3;
    readyMask = 4'b1111;
    intervalLen = 12'd10;
    pctFlat = {7'd0, 7'd30, 7'd40, 7'd20};
    doReset();
    for (int k = 0; k < 20; k++) begin
      int ph;
      int ex;
      ph = k % 10;
      ex = (ph < 2) ? 0 : (ph < 6) ? 1 : (ph < 9) ? 2 : 0;
      #1;
      chk("R8 R9 share grant", int'(grantIdx), ex);
      if (k == 0) chk("R10 no error", int'(quotaErr), 0);
      @(negedge clk);
    end

    // R10 oversubscribed: 10/70/50/0 clamps to 10/70/20/0
    pctFlat = {7'd0, 7'd50, 7'd70, 7'd10};
    readyMask = 4'b0101;
    doReset();
    for (int k = 0; k < 12; k++) begin
      int ph;
      int ex;
      ph = k % 10;
      ex = (ph == 1 || ph == 2) ? 2 : 0;
      #1;
      chk("R10 clamp grant", int'(grantIdx), ex);
      if (k == 0) chk("R10 quotaErr", int'(quotaErr), 1);
      @(negedge clk);
    end

    // R4 R5 least laxity with countdown
    policySel = 2'd2;
    readyMask = 4'b0011;
    pctFlat = '0;
    deadlineFlat = '0;
    deadlineFlat[15:0]  = 16'd100;
    deadlineFlat[31:16] = 16'd81;
    doReset();
    execFlat = '0;
    execFlat[15:0] = 16'd20;
    execLoad = 4'b0001;
    @(negedge clk);
    execLoad = '0;
    #1;
    chk("R4 laxity pick", int'(grantIdx), 0);
    @(negedge clk);
    #1;
    chk("R4 R5 tie after countdown", int'(grantIdx), 0);
    @(negedge clk);
    #1;
    chk("R4 countdown switch", int'(grantIdx), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule